// File: doc/BRIEF.md
# Multi-UART Interrupt Mux Controller

This block sits between a byte-wide host I/O bus and a bank of UART cores that occupy one contiguous address window, eight byte addresses per UART. It splits the window into one chip select per UART and passes the low three address bits through as the register offset. It also routes the UART interrupt requests onto one shared interrupt line towards the host.

The register at offset 7 of UART 0 (the lead UART's scratch slot) belongs to the mux and never reaches a UART. A write to it loads a per-channel interrupt enable mask. A read from it returns the per-channel pending mask: each request ANDed with its enable bit. When there are fewer than eight channels, the unused upper bits read as 1. The enable mask has no reset value. Software must write it once, for example 0x0F for four channels, before any channel can interrupt. A reset leaves the mask unchanged.

The host treats the shared line as edge-triggered. For that reason the line is registered, and it drops for one cycle whenever a new enabled request appears while it is already high. The host therefore sees a fresh rising edge for that request. The channel count is a parameter and may be 4 or 8.

Top module: `uart_irq_mux`

## Requirements
- R1: While `bus_sel` is high, address bits above bit 2 select UART k, and only `uart_cs[k]` is high, in the same cycle. While `bus_sel` is low, no chip select is high.
- R2: `uart_off` always equals `bus_addr[2:0]`.
- R3: An access to address 7 (offset 7 of UART 0) drives no chip select. Offset 7 of every other UART is forwarded to that UART as usual.
- R4: A write (`bus_sel` and `bus_wr` high) to address 7 loads `bus_wdata[NUM_CH-1:0]` into the enable mask at that clock edge. Bit n set to 1 enables channel n. The new mask applies from the next cycle.
- R5: While address 7 is selected, `bus_rdata` returns the pending mask in the same cycle: bit n is `uart_irq[n]` AND enable bit n. With 4 channels, bits 7..4 read 1. At every other address, `bus_rdata` equals `uart_rdata`.
- R6: A disabled channel reads 0 in its status bit and cannot raise `host_irq`.
- R7: A status bit clears in the same cycle that its UART request goes low.
- R8: `host_irq` is registered. One cycle after any enabled request is pending it is 1, and one cycle after none is pending it is 0, except in the case given in R9.
- R9: If `host_irq` is 1 and an enabled channel becomes pending that was not pending in the previous cycle, `host_irq` is 0 for exactly one cycle and then returns to 1.
- R10: Reset (`rst_n` low, sampled at the clock) forces `host_irq` to 0 and leaves the enable mask unchanged.
- R11: With `NUM_CH` = 8, the address is 6 bits wide and bits 5..3 select the UART. The status read returns all eight masked pending bits, with no bits forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access to the window this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | ADDR_W (3+log2 NUM_CH) | Byte address within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: mux status or the UART's data |
| uart_cs | output | NUM_CH | One chip select per UART |
| uart_off | output | 3 | Register offset inside the selected UART |
| uart_rdata | input | 8 | Read data returned by the selected UART |
| uart_irq | input | NUM_CH | Interrupt request from each UART |
| host_irq | output | 1 | Shared interrupt line to the host |

## Verification
Chip selects, offset, read data and status are combinational. The bench drives them at a falling edge and samples them 1 ns later, in the same cycle. A mask write takes effect at the next rising edge, so its status is read only after that edge. `host_irq` follows its cause by one rising edge, so it is checked at the next falling edge. The one-cycle retrigger dip is checked at that falling edge and at the one after. Before each mask/request combination in the exhaustive sweep, all requests are held low for two cycles, so that no unintended retrigger falls inside the checked window.

// File: rtl/uim_pkg.sv
package uim_pkg;
    localparam int          OFF_W       = 3;
    localparam int          BYTE_W      = 8;
    localparam logic [2:0]  MUX_REG_OFF = 3'd7;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/uim_decode.sv
module uim_decode
    import uim_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = CH_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_CH-1:0] uart_cs,
    output logic [OFF_W-1:0]  uart_off,
    output logic              mux_hit
);
    logic [CH_W-1:0] chan;

    assign chan     = bus_addr[ADDR_W-1:OFF_W];
    assign uart_off = bus_addr[OFF_W-1:0];
    assign mux_hit  = bus_sel && (chan == '0) && (uart_off == MUX_REG_OFF);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_cs
        assign uart_cs[k] = bus_sel && (chan == CH_W'(k)) && !mux_hit;
    end

    assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(uart_cs));
    assert_cs_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (uart_cs == '0));
    assert_lead_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == ADDR_W'(7)) |-> (uart_cs == '0));
    assert_off_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        uart_off == bus_addr[2:0]);
endmodule

// File: rtl/uim_irq_core.sv
module uim_irq_core
    import uim_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  byte_t             wdata,
    input  logic [NUM_CH-1:0] uart_irq,
    output logic [NUM_CH-1:0] pend_now,
    output logic              host_irq
);
    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] pend;
        logic              irq;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [NUM_CH-1:0] fresh;

    if (NUM_CH < BYTE_W) begin : g_spare
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^wdata[BYTE_W-1:NUM_CH];
    end

    always_comb begin
        st_d     = st_q;
        pend_now = uart_irq & st_q.en;
        fresh    = pend_now & ~st_q.pend;
        if (en_wr) begin
            st_d.en = wdata[NUM_CH-1:0];
        end
        st_d.pend = pend_now;
        st_d.irq  = (|pend_now) && !(st_q.irq && (|fresh));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en   <= st_d.en;
            st_q.pend <= '0;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_irq = st_q.irq;

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_wr) |-> (st_q.en == $past(wdata[NUM_CH-1:0])));
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(|pend_now));
    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_irq && (|pend_now)) |=> host_irq);
    assert_retrig_dip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && (|fresh)) |=> !host_irq);
    assert_reset_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !host_irq);
endmodule

// File: rtl/uart_irq_mux.sv
module uart_irq_mux
    import uim_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int ADDR_W = $clog2(NUM_CH) + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [NUM_CH-1:0] uart_cs,
    output logic [2:0]        uart_off,
    input  logic [7:0]        uart_rdata,
    input  logic [NUM_CH-1:0] uart_irq,
    output logic              host_irq
);
    logic              mux_hit;
    logic [NUM_CH-1:0] pend_now;
    byte_t             status_byte;

    initial begin
        assert_ch_count_R11: assert (NUM_CH == 4 || NUM_CH == 8);
    end

    uim_decode #(.NUM_CH(NUM_CH)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .uart_cs  (uart_cs),
        .uart_off (uart_off),
        .mux_hit  (mux_hit)
    );

    uim_irq_core #(.NUM_CH(NUM_CH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (mux_hit && bus_wr),
        .wdata    (bus_wdata),
        .uart_irq (uart_irq),
        .pend_now (pend_now),
        .host_irq (host_irq)
    );

    always_comb begin
        status_byte               = '1;
        status_byte[NUM_CH-1:0]   = pend_now;
        bus_rdata = mux_hit ? status_byte : uart_rdata;
    end

    assert_status_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_hit && uart_irq == '0) |-> (bus_rdata[NUM_CH-1:0] == '0));
endmodule

// File: tb/test_uart_irq_mux.sv
module test_uart_irq_mux;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, uart_rdata = '0, bus_rdata;
    logic [3:0] uart_cs, uart_irq = '0;
    logic [2:0] uart_off;
    logic       host_irq;

    logic       b8_sel = 1'b0, b8_wr = 1'b0;
    logic [5:0] b8_addr = '0;
    logic [7:0] b8_wdata = '0, b8_urd = '0, b8_rdata, b8_cs, b8_irq = '0;
    logic [2:0] b8_off;
    logic       b8_host;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    uart_irq_mux #(.NUM_CH(4)) i_uart_irq_mux (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .uart_cs(uart_cs), .uart_off(uart_off), .uart_rdata(uart_rdata),
        .uart_irq(uart_irq), .host_irq(host_irq));

    uart_irq_mux #(.NUM_CH(8)) i_uart_irq_mux_w8 (
        .clk(clk), .rst_n(rst_n), .bus_sel(b8_sel), .bus_wr(b8_wr),
        .bus_addr(b8_addr), .bus_wdata(b8_wdata), .bus_rdata(b8_rdata),
        .uart_cs(b8_cs), .uart_off(b8_off), .uart_rdata(b8_urd),
        .uart_irq(b8_irq), .host_irq(b8_host));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr4(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr8(input logic [7:0] d);
        @(negedge clk);
        b8_sel = 1'b1; b8_wr = 1'b1; b8_addr = 6'd7; b8_wdata = d;
        @(negedge clk);
        b8_sel = 1'b0; b8_wr = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] pat8 [4];
        pat8[0] = 8'h00; pat8[1] = 8'hFF; pat8[2] = 8'hA5; pat8[3] = 8'h3C;

        // R10: host_irq low during reset
        repeat (3) @(negedge clk);
        chk("R10 reset host_irq", host_irq, 0);
        chk("R10 reset host_irq w8", b8_host, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R5: address sweep, sel high and low
        wr4(5'd7, 8'h00);
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_addr = 5'(a); uart_rdata = 8'h3C ^ 8'(a);
            #1;
            chk(a == 7 ? "R3 lead slot cs" : "R1 cs decode", uart_cs,
                (a == 7) ? 32'd0 : (32'd1 << (a / 8)));
            chk("R2 offset", uart_off, a % 8);
            chk(a == 7 ? "R5 status read" : "R5 uart passthrough", bus_rdata,
                (a == 7) ? 32'hF0 : 32'(8'h3C ^ 8'(a)));
            bus_sel = 1'b0;
            #1;
            chk("R1 idle cs", uart_cs, 0);
        end

        // R4 R5 R6 R8: exhaustive mask x request
        for (int m = 0; m < 16; m++) begin
            for (int r = 0; r < 16; r++) begin
                uart_irq = '0;
                repeat (2) @(negedge clk);
                wr4(5'd7, {4'hA, 4'(m)});
                uart_irq = 4'(r);
                bus_sel = 1'b1; bus_addr = 5'd7;
                #1;
                chk("R4 R5 R6 status", bus_rdata, 32'hF0 | 32'(m & r));
                bus_sel = 1'b0;
                @(negedge clk);
                chk("R6 R8 host_irq", host_irq, ((m & r) != 0) ? 1 : 0);
            end
        end

        // R7: status clears with the request
        uart_irq = '0;
        wr4(5'd7, 8'h0F);
        uart_irq = 4'b0110;
        bus_sel = 1'b1; bus_addr = 5'd7;
        #1 chk("R7 status set", bus_rdata, 32'hF6);
        uart_irq = 4'b0000;
        #1 chk("R7 status clear", bus_rdata, 32'hF0);
        bus_sel = 1'b0;

        // R9 retrigger dip and R8 fall
        repeat (2) @(negedge clk);
        uart_irq = 4'b0001;
        @(negedge clk); chk("R8 rise", host_irq, 1);
        uart_irq = 4'b0011;
        @(negedge clk); chk("R9 dip", host_irq, 0);
        @(negedge clk); chk("R9 restore", host_irq, 1);
        uart_irq = 4'b0001;
        @(negedge clk); chk("R9 no dip on drop", host_irq, 1);
        uart_irq = 4'b0000;
        @(negedge clk); chk("R8 fall", host_irq, 0);

        // R10: mask survives reset
        wr4(5'd7, 8'h05);
        uart_irq = 4'hF;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset host_irq", host_irq, 0);
        rst_n = 1'b1;
        bus_sel = 1'b1; bus_addr = 5'd7;
        #1 chk("R10 mask kept", bus_rdata, 32'hF5);
        bus_sel = 1'b0;
        @(negedge clk); chk("R10 irq after reset", host_irq, 1);
        uart_irq = '0;

        // R11: eight-channel instance
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            b8_sel = 1'b1; b8_addr = 6'(a); b8_urd = 8'(a) ^ 8'h5A;
            #1;
            chk("R11 cs decode", b8_cs, (a == 7) ? 32'd0 : (32'd1 << (a / 8)));
            chk("R11 offset", b8_off, a % 8);
            b8_sel = 1'b0;
        end
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 4; r++) begin
                b8_irq = '0;
                repeat (2) @(negedge clk);
                wr8(pat8[m]);
                b8_irq = pat8[r];
                b8_sel = 1'b1; b8_addr = 6'd7;
                #1 chk("R11 status", b8_rdata, 32'(pat8[m] & pat8[r]));
                b8_sel = 1'b0;
                @(negedge clk);
                chk("R11 host_irq", b8_host, ((pat8[m] & pat8[r]) != 0) ? 1 : 0);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule